// File: doc/BRIEF.md
# Indexed UART Baud Tick Generator

This block gives a UART's transmit and receive shifters their timing. It makes a one-cycle strobe at sixteen times the chosen baud rate, and a second strobe once per bit period. Both are derived from a fixed 52 MHz reference clock. Software does not program a divisor. It writes a small table index as one byte, and the block turns that index into the rate.

The ratio between the reference and most of the rates is not a whole number. The block therefore adds a per-index increment to a phase accumulator on every clock. Each overflow of the accumulator is one oversample strobe. A 16-step phase counter then picks every sixteenth oversample strobe as the bit strobe.

Writing the index register restarts both the accumulator and the phase counter. The first bit strobe after a change therefore arrives one whole bit time later. An index outside the table runs at the slowest rate. The register still reads back the byte that was written.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `os_tick` and `bit_tick` are 0 and `rd_data` reads 0. Index 0 is the reset selection.
- R2: A byte written with `wr_en` high can be read on `rd_data` from the cycle after the write edge. It stays there until the next write.
- R3: Index values select these rates: 0 = 9600, 1 = 19200, 2 = 38400, 3 = 57600, 4 = 115200, 5 = 230400, 6 = 460800, 7 = 921600, 8 = 1843200, 9 = 3250000 baud. The long-term `os_tick` rate equals 16 × baud within 0.1 %, measured against a 52 MHz clock.
- R4: With index 9 selected, `os_tick` is high on every cycle except the one that directly follows a write.
- R5: A written byte greater than 9 makes the block run at the index-0 rate. `rd_data` still returns the byte exactly as written.
- R6: `bit_tick` is high only in a cycle where `os_tick` is also high. It marks every sixteenth `os_tick`, counted from the last write or from reset.
- R7: In the cycle after a write edge, both strobes are 0. The first `bit_tick` after the write follows it by one bit period, that is 52e6/baud clock cycles, within 1.5 cycles.
- R8: Writing the index that is already selected also restarts the strobe timing, as described in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 52 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the index register |
| wr_data | input | 8 | Index byte to write |
| rd_data | output | 8 | Byte last written to the index register |
| os_tick | output | 1 | Oversample strobe, one cycle wide, at 16 × baud |
| bit_tick | output | 1 | Bit-period strobe, coincides with every 16th `os_tick` |

## Verification
The assertions rely on three things about the inputs. `wr_en` is sampled synchronously to `clk`. `wr_data` is valid whenever `wr_en` is high. No write is issued while reset is asserted.

Under these conditions, the checker can treat every write as a clean restart. From that restart it counts oversample strobes up to each bit strobe.

The stimulus respects these conditions. It changes `wr_en` and `wr_data` only on falling clock edges. It holds each write for exactly one cycle, and it writes only after reset has been released.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    localparam int NUM_RATES = 10;
    localparam int SEL_W     = $clog2(NUM_RATES);

    // Baud rate for each table index
    function automatic longint rate_of(input int idx);
        case (idx)
            0:       return 64'd9600;
            1:       return 64'd19200;
            2:       return 64'd38400;
            3:       return 64'd57600;
            4:       return 64'd115200;
            5:       return 64'd230400;
            6:       return 64'd460800;
            7:       return 64'd921600;
            8:       return 64'd1843200;
            default: return 64'd3250000;
        endcase
    endfunction

    // Rounded accumulator step: osr * rate * 2^acc_w / ref_hz
    function automatic longint incr_of(input int idx, input int acc_w,
                                       input longint ref_hz, input int osr);
        longint num;
        num = rate_of(idx) * longint'(osr) * (64'sd1 <<< acc_w);
        return (num + ref_hz / 2) / ref_hz;
    endfunction

endpackage

// File: rtl/baud_index_reg.sv
module baud_index_reg
    import baud_tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    output logic [SEL_W-1:0] sel,
    output logic             restart
);

    logic [7:0]       raw_q;
    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] sel_d;

    // Bytes beyond the table collapse onto the slowest rate
    always_comb begin
        if (wr_data > 8'(NUM_RATES - 1)) sel_d = '0;
        else                             sel_d = wr_data[SEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
            sel_q <= '0;
        end else if (wr_en) begin
            raw_q <= wr_data;
            sel_q <= sel_d;
        end
    end

    assign rd_data = raw_q;
    assign sel     = sel_q;
    assign restart = wr_en;

endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc
    import baud_tick_pkg::*;
#(
    parameter int     ACC_W  = 24,
    parameter longint REF_HZ = 52_000_000,
    parameter int     OSR    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             carry,
    output logic             os_tick
);

    localparam int INC_W = ACC_W + 1;

    logic [INC_W-1:0] inc_tab [NUM_RATES];
    logic [ACC_W-1:0] acc_q;
    logic [INC_W-1:0] sum;

    // One increment constant per table entry
    for (genvar i = 0; i < NUM_RATES; i++) begin : g_inc
        localparam logic [INC_W-1:0] INC = INC_W'(incr_of(i, ACC_W, REF_HZ, OSR));
        assign inc_tab[i] = INC;
    end

    assign sum   = {1'b0, acc_q} + inc_tab[sel];
    assign carry = sum[ACC_W] & ~restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            os_tick <= 1'b0;
        end else if (restart) begin
            acc_q   <= '0;
            os_tick <= 1'b0;
        end else begin
            acc_q   <= sum[ACC_W-1:0];
            os_tick <= sum[ACC_W];
        end
    end

endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic carry,
    output logic bit_tick
);

    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    logic [CNT_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= '0;
            bit_tick <= 1'b0;
        end else if (restart) begin
            phase_q  <= '0;
            bit_tick <= 1'b0;
        end else if (carry) begin
            phase_q  <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
            bit_tick <= (phase_q == LAST);
        end else begin
            bit_tick <= 1'b0;
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int     ACC_W  = 24,
    parameter longint REF_HZ = 52_000_000,
    parameter int     OSR    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       os_tick,
    output logic       bit_tick
);

    logic [SEL_W-1:0] sel;
    logic             restart;
    logic             carry;

    baud_index_reg u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .sel     (sel),
        .restart (restart)
    );

    baud_phase_acc #(.ACC_W(ACC_W), .REF_HZ(REF_HZ), .OSR(OSR)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .sel     (sel),
        .carry   (carry),
        .os_tick (os_tick)
    );

    baud_bit_div #(.OSR(OSR)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .carry    (carry),
        .bit_tick (bit_tick)
    );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
    parameter int OSR = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       os_tick,
    input logic       bit_tick
);

    // Oversample strobes seen since the last bit strobe or write
    logic [7:0] os_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        os_seen <= '0;
        else if (wr_en)    os_seen <= '0;
        else if (bit_tick) os_seen <= '0;
        else if (os_tick)  os_seen <= os_seen + 1'b1;
    end

    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    a_r4_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data == 8'd9 && !$past(wr_en)) |-> os_tick);

    a_r6_bit_on_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    a_r6_sixteen_per_bit: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_seen == 8'(OSR - 1));

    a_r7_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!os_tick && !bit_tick));

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.OSR(OSR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

    localparam int  CLK_PERIOD = 20;
    localparam real REF_HZ     = 52.0e6;
    localparam int  WINDOW     = 12000;
    localparam int  WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       os_tick;
    logic       bit_tick;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    baud_tick_gen uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic real baud_of(input int idx);
        case (idx)
            0: return 9600.0;      1: return 19200.0;
            2: return 38400.0;     3: return 57600.0;
            4: return 115200.0;    5: return 230400.0;
            6: return 460800.0;    7: return 921600.0;
            8: return 1843200.0;   default: return 3250000.0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        check(rd_data == d, "R2", "readback after write", rd_data, d);
        check(!os_tick && !bit_tick, "R7", "strobes quiet after write",
              {os_tick, bit_tick}, 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(rd_data == 8'd0, "R1", "rd_data in reset", rd_data, 0);
        check(!os_tick && !bit_tick, "R1", "strobes in reset", {os_tick, bit_tick}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!os_tick && !bit_tick, "R1", "strobes first cycle", {os_tick, bit_tick}, 0);
        check(rd_data == 8'd0, "R1", "rd_data after reset", rd_data, 0);
    endtask

    // Measure oversample rate, bit spacing and coincidence over a window
    task automatic measure(input int rate_idx, input string req);
        int  os_cnt = 0;
        int  since = 0;
        int  bad_pair = 0;
        int  bad_space = 0;
        int  gaps = 0;
        real expect_n;
        real tol;
        for (int c = 0; c < WINDOW; c++) begin
            @(negedge clk);
            if (os_tick) begin
                os_cnt++;
                since++;
            end else if (rate_idx == 9) begin
                gaps++;
            end
            if (bit_tick) begin
                if (!os_tick) bad_pair++;
                if (since != 16) bad_space++;
                since = 0;
            end
        end
        expect_n = real'(WINDOW) * 16.0 * baud_of(rate_idx) / REF_HZ;
        tol = 1.5 + expect_n * 0.001;
        check((real'(os_cnt) - expect_n) <= tol && (expect_n - real'(os_cnt)) <= tol,
              req, "oversample count in window", os_cnt, longint'(expect_n));
        check(bad_pair == 0, "R6", "bit_tick without os_tick", bad_pair, 0);
        check(bad_space == 0, "R6", "os ticks per bit not 16", bad_space, 0);
        if (rate_idx == 9)
            check(gaps == 0, "R4", "missing os_tick at top rate", gaps, 0);
    endtask

    task automatic test_all_rates();
        for (int i = 0; i < 10; i++) begin
            do_write(8'(i));
            measure(i, "R3");
        end
    endtask

    task automatic test_out_of_range();
        do_write(8'd200);
        check(rd_data == 8'd200, "R5", "raw byte readback", rd_data, 200);
        measure(0, "R5");
        do_write(8'd10);
        check(rd_data == 8'd10, "R5", "raw byte 10 readback", rd_data, 10);
        measure(0, "R5");
    endtask

    task automatic first_bit(input int idx, input string req);
        int  m = 0;
        real ideal;
        do_write(8'(idx));
        while (m < 4000) begin
            @(negedge clk);
            m++;
            if (bit_tick) break;
        end
        ideal = REF_HZ / baud_of(idx);
        check((real'(m) - ideal) <= 1.5 && (ideal - real'(m)) <= 1.5, req,
              "cycles to first bit_tick", m, longint'(ideal));
    endtask

    task automatic test_restart();
        first_bit(9, "R7");
        first_bit(8, "R7");
        first_bit(7, "R7");
        first_bit(6, "R7");
        // Same index again, mid-stream
        repeat (7) @(negedge clk);
        first_bit(6, "R8");
        repeat (5) @(negedge clk);
        first_bit(9, "R8");
    endtask

    initial begin
        test_reset();
        test_all_rates();
        test_out_of_range();
        test_restart();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule